// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home-node directory for a small range of memory blocks in a shared-memory multiprocessor. The nodes reach it over a point-to-point network rather than a snooped bus. For every block it holds a sharing state (Uncached, Shared or Exclusive), a sharer bit vector with one bit per node, and an owner index. It also holds the block's memory word. Each node has its own request port, which carries read misses, write misses and writebacks. The directory answers on a single outgoing message channel with data replies, invalidates and owner fetches.

The controller runs one transaction at a time. A round-robin arbiter picks one node's request whenever the engine is idle. A request that needs other caches to act first drives a short message sequence before the requester is answered:
- A write to a shared block sends invalidates to the other sharers and counts their acknowledgements.
- A miss to an exclusively held block fetches the current data from the owner and writes it into memory.

While such a sequence is pending, every request port is held off. As a result, the order of competing writes to a block is decided only by the directory's arbitration.

Top module: `dir_ctrl`

## Requirements
- R1: After reset no message is emitted and no request port is ready until a request is presented. Every block starts Uncached with a memory value of zero.
- R2: A read miss (request kind 0) to an Uncached block yields a data message (message kind 0), addressed to the requester, carrying the block's memory value. The message is valid in the cycle right after the request is taken. The block becomes Shared with the requester as its only sharer.
- R3: A write miss (request kind 1) to an Uncached block, or from the current owner of an Exclusive block, yields a data message in the cycle right after acceptance. The block becomes Exclusive with the requester as owner.
- R4: A read miss to a Shared block yields a data message in the cycle right after acceptance and adds the requester to the sharer set.
- R5: A write miss to a Shared block sends one invalidate (message kind 1) to each sharer other than the requester. The invalidates go out one per cycle in ascending node order, starting in the cycle after acceptance, and never to the requester. The block then becomes Exclusive, owned by the requester.
- R6: The acknowledgement count starts at the number of other sharers. The data grant appears in the cycle right after the cycle in which the last acknowledgement is presented. A requester that is the only sharer is granted in the cycle after acceptance, with no invalidates.
- R7: A read miss to a block held Exclusive by another node works in three steps. First, a fetch (message kind 2) goes to the owner in the cycle after acceptance. The owner's returned data is then written to memory. Finally, a data message carries that value to the requester in the cycle after the fetch reply. The block becomes Shared by the old owner and the requester.
- R8: A write miss to a block held Exclusive by another node fetches from the owner, writes memory and returns the fetched data. The requester becomes the new owner and the block stays Exclusive.
- R9: A writeback (request kind 2) from the owner of an Exclusive block stores its data in memory, makes the block Uncached and emits no message. A writeback from any other node, or to a non-Exclusive block, changes nothing.
- R10: While a transaction is in progress, no request port is ready. Held requests are served later.
- R11: At most one port is ready per cycle. Among the valid requests, the winner is the first at or after a rotating pointer. After each acceptance the pointer moves to the node after the winner, starting from node 0 at reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NODES | One request-valid bit per node |
| req_kind | input | 2*NODES | Per-node request kind: 0 read miss, 1 write miss, 2 writeback |
| req_blk | input | BW*NODES | Per-node block index |
| req_data | input | DW*NODES | Per-node writeback data |
| req_ready | output | NODES | One-hot acceptance; a request is taken at the edge where its bit is high |
| ack_valid | input | 1 | One invalidate acknowledgement this cycle |
| fetch_valid | input | 1 | Owner's fetch reply is valid this cycle |
| fetch_data | input | DW | Data returned by the owner |
| msg_valid | output | 1 | Outgoing message valid |
| msg_kind | output | 2 | 0 data, 1 invalidate, 2 fetch |
| msg_node | output | NW | Destination node |
| msg_blk | output | BW | Block the message refers to |
| msg_data | output | DW | Data payload for data messages |

## Verification
Several properties are checked on every cycle by the assertions:
- the arbiter grants at most one valid request, and no port is ready while busy;
- invalidates never go to the requester;
- a grant after invalidation comes only once the acknowledgement count is zero;
- a reply after a fetch carries exactly the fetched data;
- directory entries written as Exclusive hold a single sharer equal to the owner.

Other behaviour can only be shown by the bench's scenarios:
- the end-to-end state histories (sharer sets built by reads, then torn down by a write);
- the exact cycle of each message;
- ignored writebacks leaving memory unchanged;
- the round-robin order when four writes to one block arrive together.

// File: rtl/dir_pkg.sv
package dir_pkg;

    localparam int DIR_NODES  = 4;
    localparam int DIR_BLOCKS = 8;
    localparam int DIR_DW     = 16;

    typedef enum logic [1:0] {
        RQ_READ  = 2'd0,
        RQ_WRITE = 2'd1,
        RQ_WBACK = 2'd2
    } rq_kind_e;

    typedef enum logic [1:0] {
        MS_DATA  = 2'd0,
        MS_INV   = 2'd1,
        MS_FETCH = 2'd2
    } ms_kind_e;

    typedef enum logic [1:0] {
        BS_UNC = 2'd0,
        BS_SHR = 2'd1,
        BS_EXC = 2'd2
    } bs_e;

    typedef enum logic [2:0] {
        CS_IDLE  = 3'd0,
        CS_INV   = 3'd1,
        CS_FETCH = 3'd2,
        CS_FWAIT = 3'd3,
        CS_REPLY = 3'd4
    } cs_e;

endpackage

// File: rtl/dir_rr_arb.sv
module dir_rr_arb #(
    parameter int N = 4,
    localparam int NW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [N-1:0]  req,
    output logic [N-1:0]  gnt,
    output logic [NW-1:0] gnt_idx
);

    logic [NW-1:0] ptr;

    always_comb begin
        int  cand;
        logic found;
        gnt     = '0;
        gnt_idx = '0;
        found   = 1'b0;
        for (int i = 0; i < N; i++) begin
            cand = (int'(ptr) + i) % N;
            if (en && !found && req[cand]) begin
                found        = 1'b1;
                gnt[cand]    = 1'b1;
                gnt_idx      = NW'(cand);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (|gnt) begin
            ptr <= (gnt_idx == NW'(N - 1)) ? '0 : gnt_idx + NW'(1);
        end
    end

    assert_single_grant_R11: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt));

    assert_grant_requested_R11: assert property (@(posedge clk) disable iff (rst)
        (gnt & ~req) == '0);

endmodule

// File: rtl/dir_table.sv
module dir_table
    import dir_pkg::*;
#(
    parameter int N  = 4,
    parameter int B  = 8,
    parameter int DW = 16,
    localparam int NW = $clog2(N),
    localparam int BW = $clog2(B)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [BW-1:0] rd_blk,
    output bs_e           rd_state,
    output logic [N-1:0]  rd_sh,
    output logic [NW-1:0] rd_owner,
    output logic [DW-1:0] rd_data,
    input  logic          ent_we,
    input  logic [BW-1:0] wr_blk,
    input  bs_e           wr_state,
    input  logic [N-1:0]  wr_sh,
    input  logic [NW-1:0] wr_owner,
    input  logic          mem_we,
    input  logic [BW-1:0] mem_blk,
    input  logic [DW-1:0] mem_wdata
);

    bs_e           st_q  [B];
    logic [N-1:0]  sh_q  [B];
    logic [NW-1:0] own_q [B];
    logic [DW-1:0] mem_q [B];

    for (genvar b = 0; b < B; b++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                st_q[b]  <= BS_UNC;
                sh_q[b]  <= '0;
                own_q[b] <= '0;
            end else if (ent_we && wr_blk == BW'(b)) begin
                st_q[b]  <= wr_state;
                sh_q[b]  <= wr_sh;
                own_q[b] <= wr_owner;
            end
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                mem_q[b] <= '0;
            end else if (mem_we && mem_blk == BW'(b)) begin
                mem_q[b] <= mem_wdata;
            end
        end
    end

    assign rd_state = st_q[rd_blk];
    assign rd_sh    = sh_q[rd_blk];
    assign rd_owner = own_q[rd_blk];
    assign rd_data  = mem_q[rd_blk];

    assert_excl_single_owner_R8: assert property (@(posedge clk) disable iff (rst)
        (ent_we && wr_state == BS_EXC) |-> ($onehot(wr_sh) && wr_sh[wr_owner]));

    assert_shared_nonempty_R4: assert property (@(posedge clk) disable iff (rst)
        (ent_we && wr_state == BS_SHR) |-> (wr_sh != '0));

    assert_uncached_empty_R9: assert property (@(posedge clk) disable iff (rst)
        (ent_we && wr_state == BS_UNC) |-> (wr_sh == '0));

endmodule

// File: rtl/dir_ack_ctr.sv
module dir_ack_ctr #(
    parameter int N = 4,
    localparam int CW = $clog2(N + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          dec,
    output logic [CW-1:0] cnt
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec && cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assert_load_nonzero_R6: assert property (@(posedge clk) disable iff (rst)
        load |-> (load_val != '0));

    assert_ack_expected_R6: assert property (@(posedge clk) disable iff (rst)
        dec |-> (cnt != '0));

endmodule

// File: rtl/dir_ctrl.sv
module dir_ctrl
    import dir_pkg::*;
#(
    parameter int NODES  = DIR_NODES,
    parameter int BLOCKS = DIR_BLOCKS,
    parameter int DW     = DIR_DW,
    localparam int NW = $clog2(NODES),
    localparam int BW = $clog2(BLOCKS),
    localparam int CW = $clog2(NODES + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NODES-1:0]      req_valid,
    input  logic [2*NODES-1:0]    req_kind,
    input  logic [BW*NODES-1:0]   req_blk,
    input  logic [DW*NODES-1:0]   req_data,
    output logic [NODES-1:0]      req_ready,
    input  logic                  ack_valid,
    input  logic                  fetch_valid,
    input  logic [DW-1:0]         fetch_data,
    output logic                  msg_valid,
    output logic [1:0]            msg_kind,
    output logic [NW-1:0]         msg_node,
    output logic [BW-1:0]         msg_blk,
    output logic [DW-1:0]         msg_data
);

    cs_e            state;
    logic           idle;
    logic [NODES-1:0] gnt;
    logic [NW-1:0]  win;
    logic           acc;

    rq_kind_e       w_kind;
    logic [BW-1:0]  w_blk;
    logic [DW-1:0]  w_data;
    logic [NODES-1:0] w_bit;

    bs_e            t_state;
    logic [NODES-1:0] t_sh;
    logic [NW-1:0]  t_owner;
    logic [DW-1:0]  t_data;
    logic [NODES-1:0] others;

    logic [NW-1:0]  cur_node;
    logic [BW-1:0]  cur_blk;
    bs_e            fin_state;
    logic [NODES-1:0] fin_sh;
    logic [NW-1:0]  fin_owner;
    logic [NODES-1:0] inv_pend;
    logic [NW-1:0]  fetch_node;

    cs_e            a_next;
    bs_e            a_fst;
    logic [NODES-1:0] a_fsh;
    logic [NW-1:0]  a_fown;
    logic           a_wb;

    logic [NW-1:0]  inv_idx;
    logic [NODES-1:0] inv_low;
    logic [NODES-1:0] pend_rest;

    logic           ack_load;
    logic [CW-1:0]  ack_cnt;
    logic           ack_done;

    logic           ent_we;
    logic [BW-1:0]  wr_blk;
    bs_e            wr_state;
    logic [NODES-1:0] wr_sh;
    logic [NW-1:0]  wr_owner;
    logic           mem_we;
    logic [DW-1:0]  mem_wdata;

    assign idle = (state == CS_IDLE);

    dir_rr_arb #(.N(NODES)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .en      (idle),
        .req     (req_valid),
        .gnt     (gnt),
        .gnt_idx (win)
    );

    assign req_ready = gnt;
    assign acc       = |gnt;
    assign w_kind    = rq_kind_e'(req_kind[2*win +: 2]);
    assign w_blk     = req_blk[BW*win +: BW];
    assign w_data    = req_data[DW*win +: DW];
    assign w_bit     = NODES'(1) << win;

    dir_table #(.N(NODES), .B(BLOCKS), .DW(DW)) u_table (
        .clk       (clk),
        .rst       (rst),
        .rd_blk    (idle ? w_blk : cur_blk),
        .rd_state  (t_state),
        .rd_sh     (t_sh),
        .rd_owner  (t_owner),
        .rd_data   (t_data),
        .ent_we    (ent_we),
        .wr_blk    (wr_blk),
        .wr_state  (wr_state),
        .wr_sh     (wr_sh),
        .wr_owner  (wr_owner),
        .mem_we    (mem_we),
        .mem_blk   (wr_blk),
        .mem_wdata (mem_wdata)
    );

    assign others = t_sh & ~w_bit;

    // Decision taken at acceptance: next step and final directory entry.
    always_comb begin
        a_next = CS_IDLE;
        a_fst  = t_state;
        a_fsh  = t_sh;
        a_fown = t_owner;
        a_wb   = 1'b0;
        case (w_kind)
            RQ_READ: begin
                case (t_state)
                    BS_UNC: begin
                        a_fst  = BS_SHR;
                        a_fsh  = w_bit;
                        a_next = CS_REPLY;
                    end
                    BS_SHR: begin
                        a_fsh  = t_sh | w_bit;
                        a_next = CS_REPLY;
                    end
                    default: begin
                        if (t_owner == win) begin
                            a_next = CS_REPLY;
                        end else begin
                            a_fst  = BS_SHR;
                            a_fsh  = t_sh | w_bit;
                            a_next = CS_FETCH;
                        end
                    end
                endcase
            end
            RQ_WRITE: begin
                a_fst  = BS_EXC;
                a_fsh  = w_bit;
                a_fown = win;
                if (t_state == BS_SHR && others != '0)
                    a_next = CS_INV;
                else if (t_state == BS_EXC && t_owner != win)
                    a_next = CS_FETCH;
                else
                    a_next = CS_REPLY;
            end
            default: begin
                a_wb = (t_state == BS_EXC) && (t_owner == win);
            end
        endcase
    end

    // Lowest pending invalidate target.
    always_comb begin
        inv_idx = '0;
        inv_low = '0;
        for (int i = NODES - 1; i >= 0; i--) begin
            if (inv_pend[i]) begin
                inv_idx = NW'(i);
                inv_low = NODES'(1) << i;
            end
        end
    end

    assign pend_rest = inv_pend & ~inv_low;
    assign ack_load  = idle && acc && (a_next == CS_INV);
    assign ack_done  = (ack_cnt == '0) || (ack_cnt == CW'(1) && ack_valid);

    dir_ack_ctr #(.N(NODES)) u_acks (
        .clk      (clk),
        .rst      (rst),
        .load     (ack_load),
        .load_val (CW'($countones(others))),
        .dec      (ack_valid && state == CS_INV),
        .cnt      (ack_cnt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= CS_IDLE;
            cur_node   <= '0;
            cur_blk    <= '0;
            fin_state  <= BS_UNC;
            fin_sh     <= '0;
            fin_owner  <= '0;
            inv_pend   <= '0;
            fetch_node <= '0;
        end else begin
            case (state)
                CS_IDLE: begin
                    if (acc) begin
                        state      <= a_next;
                        cur_node   <= win;
                        cur_blk    <= w_blk;
                        fin_state  <= a_fst;
                        fin_sh     <= a_fsh;
                        fin_owner  <= a_fown;
                        inv_pend   <= (a_next == CS_INV) ? others : '0;
                        fetch_node <= t_owner;
                    end
                end
                CS_INV: begin
                    inv_pend <= pend_rest;
                    if (pend_rest == '0 && ack_done)
                        state <= CS_REPLY;
                end
                CS_FETCH: state <= CS_FWAIT;
                CS_FWAIT: begin
                    if (fetch_valid)
                        state <= CS_REPLY;
                end
                CS_REPLY: state <= CS_IDLE;
                default:  state <= CS_IDLE;
            endcase
        end
    end

    // Directory and memory write ports.
    assign ent_we    = (state == CS_REPLY) || (idle && acc && a_wb);
    assign wr_blk    = idle ? w_blk : cur_blk;
    assign wr_state  = idle ? BS_UNC : fin_state;
    assign wr_sh     = idle ? '0 : fin_sh;
    assign wr_owner  = idle ? '0 : fin_owner;
    assign mem_we    = (idle && acc && a_wb) || (state == CS_FWAIT && fetch_valid);
    assign mem_wdata = idle ? w_data : fetch_data;

    always_comb begin
        msg_valid = 1'b0;
        msg_kind  = MS_DATA;
        msg_node  = cur_node;
        msg_blk   = cur_blk;
        msg_data  = t_data;
        case (state)
            CS_INV: begin
                msg_valid = |inv_pend;
                msg_kind  = MS_INV;
                msg_node  = inv_idx;
            end
            CS_FETCH: begin
                msg_valid = 1'b1;
                msg_kind  = MS_FETCH;
                msg_node  = fetch_node;
            end
            CS_REPLY: begin
                msg_valid = 1'b1;
            end
            default: ;
        endcase
    end

    assert_stall_while_busy_R10: assert property (@(posedge clk) disable iff (rst)
        (state != CS_IDLE) |-> (req_ready == '0));

    assert_inv_not_requester_R5: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == MS_INV) |-> (msg_node != cur_node));

    assert_grant_after_acks_R6: assert property (@(posedge clk) disable iff (rst)
        (state == CS_REPLY && $past(state) == CS_INV) |-> (ack_cnt == '0));

    assert_fetch_forwarded_R7: assert property (@(posedge clk) disable iff (rst)
        (state == CS_REPLY && $past(state) == CS_FWAIT) |-> (msg_data == $past(fetch_data)));

    assert_wb_silent_R9: assert property (@(posedge clk) disable iff (rst)
        (idle && acc && w_kind == RQ_WBACK) |=> (state == CS_IDLE && !msg_valid));

endmodule

// File: tb/sim_dir_ctrl.sv
module sim_dir_ctrl;

    localparam int N  = 4;
    localparam int B  = 8;
    localparam int DW = 16;
    localparam int NW = 2;
    localparam int BW = 3;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic              rst;
    logic [N-1:0]      req_valid;
    logic [2*N-1:0]    req_kind;
    logic [BW*N-1:0]   req_blk;
    logic [DW*N-1:0]   req_data;
    logic [N-1:0]      req_ready;
    logic              ack_valid;
    logic              fetch_valid;
    logic [DW-1:0]     fetch_data;
    logic              msg_valid;
    logic [1:0]        msg_kind;
    logic [NW-1:0]     msg_node;
    logic [BW-1:0]     msg_blk;
    logic [DW-1:0]     msg_data;

    dir_ctrl u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_kind(req_kind),
        .req_blk(req_blk), .req_data(req_data), .req_ready(req_ready),
        .ack_valid(ack_valid), .fetch_valid(fetch_valid), .fetch_data(fetch_data),
        .msg_valid(msg_valid), .msg_kind(msg_kind), .msg_node(msg_node),
        .msg_blk(msg_blk), .msg_data(msg_data)
    );

    int cyc = 0;
    always @(posedge clk) cyc++;

    int checks = 0;
    int fails  = 0;
    bit running = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference: block states 0 U, 1 S, 2 E.
    int m_st  [B];
    int m_sh  [B];
    int m_own [B];
    int m_mem [B];
    int m_ptr = 0;

    typedef struct {
        int    kind;
        int    node;
        int    blk;
        int    data;
        int    mode;   // 0 fixed cycle, 1 after last ack, 2 after fetch reply
        int    due;
        string tag;
    } exp_t;
    exp_t q[$];

    int pend_acks = 0;
    int fetch_cnt = 0;
    int fetch_n = 0;
    int fetch_b = 0;
    int last_ack = -10;
    int last_fetch = -10;

    function automatic int fval(int o, int b);
        return 'hC000 | (o << 8) | b;
    endfunction

    function automatic void push(int k, int n, int b, int d, int mode, int due, string tag);
        exp_t e;
        e.kind = k; e.node = n; e.blk = b; e.data = d;
        e.mode = mode; e.due = due; e.tag = tag;
        q.push_back(e);
    endfunction

    function automatic void model_accept(int n, int a);
        int k, b, d, others, j;
        k = int'(req_kind[2*n +: 2]);
        b = int'(req_blk[BW*n +: BW]);
        d = int'(req_data[DW*n +: DW]);
        if (k == 0) begin
            if (m_st[b] == 0) begin
                push(0, n, b, m_mem[b], 0, a + 1, "R2 uncached read");
                m_st[b] = 1; m_sh[b] = 1 << n;
            end else if (m_st[b] == 1) begin
                push(0, n, b, m_mem[b], 0, a + 1, "R4 shared read");
                m_sh[b] |= 1 << n;
            end else if (m_own[b] == n) begin
                push(0, n, b, m_mem[b], 0, a + 1, "R7 owner read");
            end else begin
                push(2, m_own[b], b, 0, 0, a + 1, "R7 fetch");
                m_mem[b] = fval(m_own[b], b);
                push(0, n, b, m_mem[b], 2, 0, "R7 data after fetch");
                m_st[b] = 1; m_sh[b] = (1 << m_own[b]) | (1 << n);
            end
        end else if (k == 1) begin
            if (m_st[b] == 0) begin
                push(0, n, b, m_mem[b], 0, a + 1, "R3 uncached write");
            end else if (m_st[b] == 1) begin
                others = m_sh[b] & ~(1 << n);
                j = 0;
                for (int i = 0; i < N; i++) begin
                    if (others[i]) begin
                        push(1, i, b, 0, 0, a + 1 + j, "R5 invalidate");
                        j++;
                    end
                end
                if (others != 0) push(0, n, b, m_mem[b], 1, 0, "R6 grant after acks");
                else             push(0, n, b, m_mem[b], 0, a + 1, "R6 sole sharer upgrade");
            end else if (m_own[b] == n) begin
                push(0, n, b, m_mem[b], 0, a + 1, "R3 owner write");
            end else begin
                push(2, m_own[b], b, 0, 0, a + 1, "R8 fetch");
                m_mem[b] = fval(m_own[b], b);
                push(0, n, b, m_mem[b], 2, 0, "R8 data after fetch");
            end
            m_st[b] = 2; m_sh[b] = 1 << n; m_own[b] = n;
        end else begin
            if (m_st[b] == 2 && m_own[b] == n) begin
                m_mem[b] = d; m_st[b] = 0; m_sh[b] = 0;
            end
        end
    endfunction

    // Monitor: samples mid-cycle, away from the active edge.
    always @(negedge clk) begin
        if (running && !rst) begin
            if (q.size() != 0 && req_valid != '0)
                chk(req_ready == '0, "R10 stall while busy", int'(req_ready), 0);
            if (req_ready != '0) begin
                int w;
                w = -1;
                for (int i = 0; i < N; i++) begin
                    int c;
                    c = (m_ptr + i) % N;
                    if (w < 0 && req_valid[c]) w = c;
                end
                chk(w >= 0 && req_ready == (N'(1) << w), "R11 round-robin winner",
                    int'(req_ready), (w >= 0) ? (1 << w) : 0);
                if (w >= 0 && req_ready[w]) begin
                    m_ptr = (w + 1) % N;
                    model_accept(w, cyc);
                end
            end
            if (msg_valid) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R9 unexpected message", int'(msg_kind), -1);
                end else begin
                    exp_t e;
                    int act, expv, due;
                    e = q.pop_front();
                    act  = (int'(msg_kind) << 28) | (int'(msg_node) << 24) | (int'(msg_blk) << 20)
                         | ((e.kind == 0) ? int'(msg_data) : 0);
                    expv = (e.kind << 28) | (e.node << 24) | (e.blk << 20)
                         | ((e.kind == 0) ? e.data : 0);
                    chk(act == expv, e.tag, act, expv);
                    due = (e.mode == 0) ? e.due : (e.mode == 1) ? last_ack + 1 : last_fetch + 1;
                    chk(cyc == due, {e.tag, " timing"}, cyc, due);
                end
                if (msg_kind == 2'd1) pend_acks++;
                if (msg_kind == 2'd2) begin
                    fetch_cnt = 2; fetch_n = int'(msg_node); fetch_b = int'(msg_blk);
                end
            end
            if (ack_valid)   last_ack   = cyc;
            if (fetch_valid) last_fetch = cyc;
        end
    end

    // Cache-side responders, driven just after the edge.
    always @(posedge clk) begin
        #1;
        if (rst) begin
            ack_valid = 1'b0; fetch_valid = 1'b0; fetch_data = '0;
        end else begin
            if (pend_acks > 0) begin
                ack_valid = 1'b1; pend_acks--;
            end else begin
                ack_valid = 1'b0;
            end
            if (fetch_cnt > 0) begin
                fetch_cnt--;
                fetch_valid = (fetch_cnt == 0);
                fetch_data  = DW'(fval(fetch_n, fetch_b));
            end else begin
                fetch_valid = 1'b0;
            end
        end
    end

    task automatic do_req(input int n, input int k, input int b, input int d);
        @(posedge clk); #1;
        req_kind[2*n +: 2]   = 2'(k);
        req_blk[BW*n +: BW]  = BW'(b);
        req_data[DW*n +: DW] = DW'(d);
        req_valid[n]         = 1'b1;
        forever begin
            @(negedge clk);
            if (req_ready[n]) break;
        end
        @(posedge clk); #1;
        req_valid[n] = 1'b0;
    endtask

    task automatic settle();
        while (q.size() != 0 || pend_acks > 0 || fetch_cnt > 0) @(posedge clk);
        repeat (3) @(posedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog R10 actual=hung expected=complete");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1; req_valid = '0; req_kind = '0; req_blk = '0; req_data = '0;
        ack_valid = 1'b0; fetch_valid = 1'b0; fetch_data = '0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(msg_valid == 1'b0, "R1 no message after reset", int'(msg_valid), 0);
        chk(req_ready == '0, "R1 no ready after reset", int'(req_ready), 0);
        running = 1'b1;

        // Uncached read, then two more readers build a sharer set.
        do_req(0, 0, 1, 0); settle();
        do_req(1, 0, 1, 0); settle();
        do_req(2, 0, 1, 0); settle();
        // Write to shared block: invalidates to 0,1,2, grant after last ack.
        do_req(3, 1, 1, 0); settle();
        // Read of an exclusive block from another node: fetch from owner 3.
        do_req(0, 0, 1, 0); settle();
        // Uncached write, then owner rewrites without any fetch.
        do_req(1, 1, 2, 0); settle();
        do_req(1, 1, 2, 0); settle();
        // Write from non-owner: fetch from owner 1, ownership moves to 2.
        do_req(2, 1, 2, 0); settle();
        // Owner writeback, then a read sees the written value with no fetch.
        do_req(2, 2, 2, 'h1234); settle();
        do_req(0, 0, 2, 0); settle();
        // Ignored writebacks: shared block, and non-owner.
        do_req(3, 2, 1, 'hDEAD); settle();
        do_req(0, 2, 2, 'hBEEF); settle();
        do_req(1, 0, 1, 0); settle();
        do_req(3, 0, 2, 0); settle();
        // Exclusive block, writeback by a non-owner.
        do_req(3, 1, 4, 0); settle();
        do_req(1, 2, 4, 'h5555); settle();
        do_req(2, 0, 4, 0); settle();
        // Sole-sharer upgrade: no invalidates.
        do_req(0, 0, 6, 0); settle();
        do_req(0, 1, 6, 0); settle();
        // Four writes to one block at once: round-robin order and fetch chain.
        fork
            do_req(0, 1, 5, 0);
            do_req(1, 1, 5, 0);
            do_req(2, 1, 5, 0);
            do_req(3, 1, 5, 0);
        join
        settle();
        // Four reads of that block at once.
        fork
            do_req(0, 0, 5, 0);
            do_req(1, 0, 5, 0);
            do_req(2, 0, 5, 0);
            do_req(3, 0, 5, 0);
        join
        settle();
        // Write to a block shared by all four: three invalidates.
        do_req(1, 1, 5, 0); settle();

        chk(q.size() == 0, "R2 all expected messages seen", q.size(), 0);
        running = 1'b0;
        summary();
        $finish;
    end

endmodule